// File: doc/BRIEF.md
# Dual-Mode Burst Address Generator

This block sits in the front end of a synchronous memory and supplies the address for a four-beat burst. A start address is taken from the address bus on any rising clock edge where either the processor strobe or the controller strobe is held low. After that load, each edge with the advance input low moves the burst forward by one beat. The low two bits of the output come from a two-bit beat counter. The upper bits keep the loaded value until the next load.

Two beat orders are offered, and the mode pin chooses between them at run time. Linear order counts the low bits up modulo four from the start value. Interleaved order XORs the start bits with the beat number. This supports the usual 3-1-1-1 access pattern: one addressed access followed by three back-to-back beats. The block has only level-sensitive control pins and no data stream, so none of its ports use a valid/ready handshake and no back-pressure applies.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low, and after reset until the first load, addr_out is all zeros.
- R2: On a rising edge where proc_strobe_n or ctrl_strobe_n is low (either one or both), the full addr_in is captured and the beat count returns to 0. From the next cycle addr_out equals the captured address.
- R3: On an edge with advance_n low and both strobes high, the beat count rises by one modulo 4. The bits above bit 1 of addr_out do not change.
- R4: With order_sel = 0 (linear), addr_out[1:0] equals (start + beat) modulo 4. For example, start 01 gives 01, 10, 11, 00.
- R5: With order_sel = 1 (interleaved), addr_out[1:0] equals start XOR beat. For example, start 01 gives 01, 00, 11, 10.
- R6: On an edge with advance_n high and both strobes high, addr_out keeps its value, so one beat position can be repeated.
- R7: A strobe on the same edge as a low advance_n wins. The address is reloaded, the beat count becomes 0, and the advance has no effect.
- R8: A fourth advance after a load wraps the beat count to 0, which returns addr_out[1:0] to the start bits.
- R9: order_sel acts as a level on the stored start and beat count. Changing it alters addr_out[1:0] in the same cycle, and the beat count is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | External address bus |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Beat order: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Registered address with burst low bits |

## Verification
The bench builds the block with ADDR_W = 8, which leaves six upper bits. That is enough to give every load a distinct upper field, so a stray change to the upper bits during a burst would show up. With the beat counter fixed at two bits, the bench sweeps every start value in both orders through both strobes and wraps past the fourth beat, which covers the whole burst state space. Directed cases are added for a hold in the middle of a burst, a strobe on the same edge as advance, both strobes at once, and a switch of order in the middle of a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl (
  input  logic proc_strobe_n,
  input  logic ctrl_strobe_n,
  input  logic advance_n,
  output logic load,
  output logic step
);
  // Either strobe loads; advance only counts when no strobe is present.
  always_comb begin
    load = ~proc_strobe_n | ~ctrl_strobe_n;
    step = ~load & ~advance_n;
  end
endmodule

// File: rtl/burst_counter.sv
module burst_counter
  import burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  step,
  input  beat_t start_in,
  output beat_t start_q,
  output beat_t count_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      count_q <= '0;
    end else if (load) begin
      start_q <= start_in;
      count_q <= '0;
    end else if (step) begin
      count_q <= count_q + beat_t'(1);
    end
  end

  // R7: a load always restarts the beat count
  a_r7_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count_q == '0));
  // R3: a step moves the count by exactly one, modulo four
  a_r3_step_once: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (count_q == beat_t'($past(count_q) + beat_t'(1))));
  // R6: with neither load nor step the state is frozen
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> ($stable(count_q) && $stable(start_q)));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
(
  input  beat_t  start_q,
  input  beat_t  count_q,
  input  order_e order,
  output beat_t  low_bits
);
  always_comb begin
    unique case (order)
      ORD_INTERLEAVE: low_bits = start_q ^ count_q;
      default:        low_bits = start_q + count_q;
    endcase
  end

  // R5/R4: beat zero always lands on the start bits in either order
  always_comb begin
    if (count_q == '0) a_r4_beat0_start: assert (low_bits == start_q);
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              advance_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic            load, step;
  beat_t           start_q, count_q, low_bits;
  logic [HI_W-1:0] hi_q;

  burst_load_ctrl u_ctrl (
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .advance_n     (advance_n),
    .load          (load),
    .step          (step)
  );

  burst_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (step),
    .start_in (addr_in[BEAT_W-1:0]),
    .start_q  (start_q),
    .count_q  (count_q)
  );

  burst_order_map u_map (
    .start_q  (start_q),
    .count_q  (count_q),
    .order    (order_e'(order_sel)),
    .low_bits (low_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_q <= '0;
    else if (load) hi_q <= addr_in[ADDR_W-1:BEAT_W];
  end

  assign addr_out = {hi_q, low_bits};

  // R2: either strobe presents the captured address on the next cycle
  a_r2_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe_n || !ctrl_strobe_n) |=> (addr_out == $past(addr_in)));
  // R3: the upper field is untouched without a strobe
  a_r3_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_strobe_n && ctrl_strobe_n) |=>
      (addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W])));
  // R4: a linear step adds one to the low bits while the order stays linear
  a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_strobe_n && ctrl_strobe_n && !advance_n && !order_sel) |=>
      (order_sel || addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1)));
endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          proc_n = 1'b1, ctrl_n = 1'b1, adv_n = 1'b1, ord = 1'b0;
  logic [AW-1:0] addr_out;
  int n_cmp = 0, n_bad = 0;
  logic done = 1'b0;

  burst_addr_gen #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .proc_strobe_n(proc_n), .ctrl_strobe_n(ctrl_n),
    .advance_n(adv_n), .order_sel(ord), .addr_out(addr_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [AW-1:0] exp);
    n_cmp++;
    if (addr_out !== exp) begin
      n_bad++;
      $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic logic [1:0] ref_low(logic [1:0] s, logic [1:0] k, logic m);
    return m ? (s ^ k) : 2'(s + k);
  endfunction

  task automatic load_addr(input logic [AW-1:0] a, input logic use_ctrl);
    addr_in = a;
    if (use_ctrl) ctrl_n = 1'b0; else proc_n = 1'b0;
    tick;
    proc_n = 1'b1;
    ctrl_n = 1'b1;
    addr_in = ~a;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary;
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] base;
    // R1: reset state
    tick; tick;
    chk("R1 in reset", '0);
    rst_n = 1'b1;
    tick;
    chk("R1 after reset", '0);

    // Sweep: both orders, all starts, both strobes, wrap past beat four
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int w = 0; w < 2; w++) begin
          ord  = m[0];
          base = {6'(m * 16 + s * 4 + w * 2 + 1), 2'(s)};
          load_addr(base, w[0]);
          chk("R2 load", base);
          for (int k = 1; k <= 4; k++) begin
            adv_n = 1'b0;
            tick;
            adv_n = 1'b1;
            if (k == 4)
              chk("R8 wrap", base);
            else if (m == 1)
              chk("R3 R5 interleaved", {base[AW-1:2], ref_low(2'(s), 2'(k), 1'b1)});
            else
              chk("R3 R4 linear", {base[AW-1:2], ref_low(2'(s), 2'(k), 1'b0)});
            if (k == 2) begin
              tick;
              chk("R6 hold", {base[AW-1:2], ref_low(2'(s), 2'(k), m[0])});
            end
          end
        end
      end
    end

    // R7: strobe with advance on the same edge
    ord = 1'b0;
    load_addr(8'hA5, 1'b0);
    adv_n = 1'b0; tick; tick;
    chk("R7 pre", 8'hA7);
    addr_in = 8'h3E; proc_n = 1'b0;
    tick;
    proc_n = 1'b1; adv_n = 1'b1;
    chk("R7 load wins", 8'h3E);
    adv_n = 1'b0; tick; adv_n = 1'b1;
    chk("R7 count restarted", 8'h3F);

    // R2: both strobes together
    addr_in = 8'hC2; proc_n = 1'b0; ctrl_n = 1'b0;
    tick;
    proc_n = 1'b1; ctrl_n = 1'b1;
    chk("R2 both strobes", 8'hC2);

    // R9: order switch mid-burst
    load_addr(8'h91, 1'b1);
    adv_n = 1'b0; tick; adv_n = 1'b1;
    chk("R9 linear beat1", 8'h92);
    ord = 1'b1; #1;
    chk("R9 switched to interleaved", 8'h90);
    ord = 1'b0; #1;
    chk("R9 back to linear", 8'h92);
    adv_n = 1'b0; tick; adv_n = 1'b1;
    chk("R9 count kept", 8'h93);

    done = 1'b1;
    summary;
    $finish;
  end
endmodule